// File: doc/BRIEF.md
# Two-Wire Converter Control Slave

This block is the digital front end of a small multichannel 8-bit converter that a host controls over a two-wire serial bus. It oversamples the clock and data lines on the system clock and recognises bus start and stop conditions. It shifts in bytes, each taking nine clocks with the last clock for the acknowledge. The slave answers only its own 7-bit address. Each data byte written to it goes to one of two control registers, chosen by the byte's top bit. The first register, called setup, holds the reference selection, the conversion clock source and the polarity request. The second, called configuration, holds the input channel and the single-ended or differential mode.

On a read, the slave returns the current conversion result one byte at a time. The analog core is stood in for by a signed raw difference input. The result is coded as straight binary when the effective mode is unipolar and as two's complement when it is bipolar. Unipolar is forced whenever the input is single-ended. The decoded fields are brought out as ports so the analog side can use them directly.

Top module: `adc_twi_frontend`

## Requirements
- R1: Bus activity before a START condition (data falling while the clock is high) is ignored: no acknowledge is driven and no register changes.
- R2: After START, the slave pulls SDA low during the ninth clock only if the 7-bit address equals DEV_ADDR (default 0x64; address in bits 7:1, read when bit 0 is 1). For any other address it leaves SDA released for the rest of the transaction and writes nothing.
- R3: Each complete byte written after a matching write address is acknowledged. Bit 7 = 1 sends it to the setup register and bit 7 = 0 to the configuration register, and the other register keeps its value.
- R4: Setup byte fields: bits 6:4 give vref_sel, bit 3 gives ext_clk_sel (1 external), and bit 2 is the bipolar request (1 bipolar).
- R5: Configuration byte fields: bits 4:1 give chan_sel and bit 0 gives single_end (1 single-ended, 0 differential). Bits 6:5 have no effect.
- R6: After reset vref_sel = 0, ext_clk_sel = 0, bipolar request = 0, chan_sel = 0, single_end = 1, and SDA is released.
- R7: A setup byte with bit 1 = 0 stores its setup fields and, in the same write, returns the configuration register to its reset value. With bit 1 = 1 the configuration register is unchanged.
- R8: bipolar_mode is 1 only when the bipolar request is 1 and single_end is 0.
- R9: In unipolar mode the read code is 0 for a negative conv_diff and conv_diff as an unsigned byte otherwise.
- R10: In bipolar mode the read code is conv_diff in two's complement, clamped to the range -128 to 127.
- R11: Read data goes out MSB first and SDA changes only while SCL is low. The result is reloaded after a host acknowledge, and SDA is released for good after a host not-acknowledge.
- R12: A STOP, or a repeated START, arriving before the eighth bit of a byte discards that byte. The next transaction then behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_pull | output | 1 | 1 pulls the open-drain data line low |
| conv_diff | input | CODE_W+1 | Signed raw difference from the analog core |
| vref_sel | output | 3 | Decoded reference selection |
| ext_clk_sel | output | 1 | 1 selects the external conversion clock |
| bipolar_mode | output | 1 | Effective polarity after single-ended forcing |
| chan_sel | output | 4 | Selected input channel |
| single_end | output | 1 | 1 single-ended, 0 pseudo-differential |

## Verification
One write can update the setup register and reset the configuration register at the same moment. The bench provokes this by setting a non-default channel and differential mode, then writing a setup byte whose reset bit is 0. In the settled cycles that follow, every setup field and both configuration fields must match the reference model together. The polarity derived from both registers is judged in the same comparison. A second case sets the bipolar request while single-ended is selected and then reads a negative input, which must come back as code 0.

// File: rtl/adc_twi_pkg.sv
package adc_twi_pkg;
  localparam int TWI_BYTE_W = 8;
  localparam int VREF_W     = 3;
  localparam int CHAN_W     = 4;

  // byte field positions that the register bank decodes
  localparam int POS_TARGET  = 7;
  localparam int POS_VREF_LO = 4;
  localparam int POS_EXTCLK  = 3;
  localparam int POS_BIPREQ  = 2;
  localparam int POS_KEEPCFG = 1;
  localparam int POS_CHAN_LO = 1;
  localparam int POS_SINGLE  = 0;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_WDATA,
    LK_ACK,
    LK_RDATA,
    LK_RACK,
    LK_SKIP
  } link_st_e;

  typedef struct packed {
    logic [VREF_W-1:0] vref;
    logic              ext_clk;
    logic              bip_req;
  } setup_t;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              single;
  } cfg_t;

  localparam setup_t SETUP_DEF = '{vref: '0, ext_clk: 1'b0, bip_req: 1'b0};
  localparam cfg_t   CFG_DEF   = '{chan: '0, single: 1'b1};
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_in};
      sda_sh <= {sda_sh[LAST-1:0], sda_in};
      scl_d  <= scl_sh[LAST];
      sda_d  <= sda_sh[LAST];
    end
  end

  assign scl_hi   = scl_sh[LAST];
  assign sda_hi   = sda_sh[LAST];
  assign scl_rise = scl_hi & ~scl_d;
  assign scl_fall = ~scl_hi & scl_d;
  // a data edge counts as a bus condition only when the clock was high before and after
  assign start_ev = scl_hi & scl_d & sda_d & ~sda_hi;
  assign stop_ev  = scl_hi & scl_d & ~sda_d & sda_hi;
endmodule

// File: rtl/twi_link.sv
module twi_link
  import adc_twi_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-2:0] DEV_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_hi,
  input  logic              sda_hi,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam int              CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  link_st_e          state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rd_mode, mst_ack;

  // named events for the checks below
  logic byte_done, addr_hit, rx_shift;
  assign byte_done = scl_fall && (bit_cnt == CNT_FULL);
  assign addr_hit  = (rx_sh[BYTE_W-1:1] == DEV_ADDR);
  assign rx_shift  = scl_rise && (bit_cnt != CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LK_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rd_mode  <= 1'b0;
      mst_ack  <= 1'b0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_byte  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state    <= LK_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= LK_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          LK_ADDR, LK_WDATA: begin
            if (rx_shift) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_hi};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              if (state == LK_ADDR) begin
                if (addr_hit) begin
                  rd_mode  <= rx_sh[0];
                  sda_pull <= 1'b1;
                  state    <= LK_ACK;
                end else begin
                  state <= LK_SKIP;
                end
              end else begin
                wr_en    <= 1'b1;
                wr_byte  <= rx_sh;
                rd_mode  <= 1'b0;
                sda_pull <= 1'b1;
                state    <= LK_ACK;
              end
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                tx_sh    <= tx_byte << 1;
                sda_pull <= ~tx_byte[BYTE_W-1];
                state    <= LK_RDATA;
              end else begin
                sda_pull <= 1'b0;
                state    <= LK_WDATA;
              end
            end
          end
          LK_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == CNT_FULL) begin
                sda_pull <= 1'b0;
                state    <= LK_RACK;
              end else begin
                sda_pull <= ~tx_sh[BYTE_W-1];
                tx_sh    <= tx_sh << 1;
              end
            end
          end
          LK_RACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_hi;
            end else if (scl_fall) begin
              if (mst_ack) begin
                bit_cnt  <= '0;
                tx_sh    <= tx_byte << 1;
                sda_pull <= ~tx_byte[BYTE_W-1];
                state    <= LK_RDATA;
              end else begin
                state <= LK_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_hi) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pull)); // R11
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_SKIP) |-> !sda_pull); // R2
  AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall)); // R12
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R3
endmodule

// File: rtl/cvt_ctrl_regs.sv
module cvt_ctrl_regs
  import adc_twi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TWI_BYTE_W-1:0] wr_byte,
  output setup_t                setup_q,
  output cfg_t                  cfg_q
);
  logic to_setup, keep_cfg;
  assign to_setup = wr_byte[POS_TARGET];
  assign keep_cfg = wr_byte[POS_KEEPCFG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= SETUP_DEF;
      cfg_q   <= CFG_DEF;
    end else if (wr_en) begin
      if (to_setup) begin
        setup_q.vref    <= wr_byte[POS_VREF_LO +: VREF_W];
        setup_q.ext_clk <= wr_byte[POS_EXTCLK];
        setup_q.bip_req <= wr_byte[POS_BIPREQ];
        if (!keep_cfg) cfg_q <= CFG_DEF;
      end else begin
        cfg_q.chan   <= wr_byte[POS_CHAN_LO +: CHAN_W];
        cfg_q.single <= wr_byte[POS_SINGLE];
      end
    end
  end

  AST_SOFT_RST_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && to_setup && !keep_cfg) |=> (cfg_q == CFG_DEF)); // R7
  AST_KEEP_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && to_setup && keep_cfg) |=> $stable(cfg_q)); // R7
  AST_CFG_SPARES_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !to_setup) |=> $stable(setup_q)); // R3
endmodule

// File: rtl/cvt_code_fmt.sv
module cvt_code_fmt #(
  parameter int CODE_W = 8
) (
  input  logic signed [CODE_W:0] diff,
  input  logic                   bipolar,
  output logic [CODE_W-1:0]      code
);
  function automatic logic [CODE_W-1:0] fmt_code(input logic signed [CODE_W:0] d, input logic bip);
    int dv, hi, lo;
    dv = int'(d);
    hi = (1 << (CODE_W - 1)) - 1;
    lo = -(1 << (CODE_W - 1));
    if (!bip) begin
      fmt_code = (dv < 0) ? '0 : d[CODE_W-1:0];
    end else if (dv > hi) begin
      fmt_code = {1'b0, {(CODE_W-1){1'b1}}};
    end else if (dv < lo) begin
      fmt_code = {1'b1, {(CODE_W-1){1'b0}}};
    end else begin
      fmt_code = d[CODE_W-1:0];
    end
  endfunction

  assign code = fmt_code(diff, bipolar);
endmodule

// File: rtl/adc_twi_frontend.sv
module adc_twi_frontend
  import adc_twi_pkg::*;
#(
  parameter int         CODE_W      = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_pull,
  input  logic signed [CODE_W:0] conv_diff,
  output logic [VREF_W-1:0]      vref_sel,
  output logic                   ext_clk_sel,
  output logic                   bipolar_mode,
  output logic [CHAN_W-1:0]      chan_sel,
  output logic                   single_end
);
  logic scl_hi, sda_hi, scl_rise, scl_fall, start_ev, stop_ev;
  logic                  wr_en;
  logic [TWI_BYTE_W-1:0] wr_byte;
  logic [CODE_W-1:0]     rd_code;
  setup_t                setup_q;
  cfg_t                  cfg_q;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_link #(.BYTE_W(TWI_BYTE_W), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_hi(sda_hi),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_byte(rd_code), .sda_pull(sda_pull), .wr_en(wr_en), .wr_byte(wr_byte)
  );

  cvt_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
    .setup_q(setup_q), .cfg_q(cfg_q)
  );

  // single-ended inputs are always coded unipolar
  assign bipolar_mode = setup_q.bip_req & ~cfg_q.single;

  cvt_code_fmt #(.CODE_W(CODE_W)) u_fmt (
    .diff(conv_diff), .bipolar(bipolar_mode), .code(rd_code)
  );

  assign vref_sel    = setup_q.vref;
  assign ext_clk_sel = setup_q.ext_clk;
  assign chan_sel    = cfg_q.chan;
  assign single_end  = cfg_q.single;
endmodule

// File: tb/adc_twi_frontend_bench.sv
module adc_twi_frontend_bench;
  localparam int         T    = 8;
  localparam logic [6:0] ADDR = 7'h64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, ext_clk_sel, bipolar_mode, single_end;
  logic sda_line;
  logic signed [8:0] conv_diff = '0;
  logic [2:0] vref_sel;
  logic [3:0] chan_sel;

  assign sda_line = sda_m & ~sda_pull;

  adc_twi_frontend u_adc_twi_frontend (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .conv_diff(conv_diff), .vref_sel(vref_sel), .ext_clk_sel(ext_clk_sel),
    .bipolar_mode(bipolar_mode), .chan_sel(chan_sel), .single_end(single_end)
  );

  int checks = 0, failures = 0;
  int m_vref = 0, m_ext = 0, m_bip = 0, m_chan = 0, m_se = 1;
  bit model_ok = 1'b0;
  bit pull_seen = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural register model
  task automatic model_write(input int b);
    if (b >= 128) begin
      m_vref = (b / 16) % 8;
      m_ext  = (b / 8) % 2;
      m_bip  = (b / 4) % 2;
      if ((b / 2) % 2 == 0) begin m_chan = 0; m_se = 1; end
    end else begin
      m_chan = (b / 2) % 16;
      m_se   = b % 2;
    end
  endtask

  function automatic int exp_code(input int d, input bit bip);
    if (!bip) return (d < 0) ? 0 : d;
    if (d > 127) return 127;
    if (d < -128) return 128;
    return (d < 0) ? d + 256 : d;
  endfunction

  always @(negedge clk) begin
    if (sda_pull) pull_seen = 1'b1;
    if (rst_n && model_ok) begin
      chk("R4 vref", int'(vref_sel), m_vref);
      chk("R4 extclk", int'(ext_clk_sel), m_ext);
      chk("R5 chan", int'(chan_sel), m_chan);
      chk("R5 single", int'(single_end), m_se);
      chk("R8 bipolar", int'(bipolar_mode), int'(m_bip == 1 && m_se == 0));
    end
  end

  task automatic hp(); repeat (T) @(negedge clk); endtask
  task automatic qp(); repeat (T/2) @(negedge clk); endtask

  task automatic bus_start();
    model_ok = 1'b0;
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hp(); scl_m = 1'b1; qp(); acked = !sda_line; qp(); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1; qp(); b[i] = sda_line; qp(); scl_m = 1'b0;
    end
  endtask

  task automatic mack(input bit ack);
    sda_m = !ack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    model_ok = 1'b1;
  endtask

  task automatic write_txn(input logic [7:0] b0, input logic [7:0] b1, input int n);
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); chk("R2 address ack", int'(a), 1);
    send_byte(b0, a);           chk("R3 byte ack", int'(a), 1);
    if (n > 1) begin send_byte(b1, a); chk("R3 byte ack", int'(a), 1); end
    bus_stop();
    model_write(int'(b0));
    if (n > 1) model_write(int'(b1));
    settle();
  endtask

  task automatic read_one(input int d, input bit last, input string req);
    logic [7:0] got;
    conv_diff = 9'(d);
    recv_byte(got);
    chk(req, int'(got), exp_code(d, (m_bip == 1 && m_se == 0)));
    mack(!last);
  endtask

  task automatic read_begin();
    bit a;
    bus_start();
    send_byte({ADDR, 1'b1}, a); chk("R2 read address ack", int'(a), 1);
  endtask

  task automatic read_end();
    hp(); chk("R11 released after host nack", int'(sda_pull), 0);
    bus_stop(); settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R6 reset values
    chk("R6 vref", int'(vref_sel), 0);
    chk("R6 extclk", int'(ext_clk_sel), 0);
    chk("R6 bipolar", int'(bipolar_mode), 0);
    chk("R6 chan", int'(chan_sel), 0);
    chk("R6 single", int'(single_end), 1);
    chk("R6 sda released", int'(sda_pull), 0);
    model_ok = 1'b1;

    // R1 clocking with no START
    pull_seen = 1'b0;
    scl_m = 1'b0; hp();
    for (int i = 7; i >= 0; i--) send_bit(ADDR[i > 0 ? i - 1 : 0] & (i > 0));
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    chk("R1 no ack without start", int'(pull_seen), 0);
    chk("R1 chan untouched", int'(chan_sel), 0);

    // R3 R4 R5 setup then config in one transaction
    write_txn(8'hB6, 8'h0E, 2);
    chk("R4 vref after setup", int'(vref_sel), 3);
    chk("R5 chan after config", int'(chan_sel), 7);
    chk("R8 bipolar in differential", int'(bipolar_mode), 1);
    // R5 bits 6:5 have no effect
    write_txn(8'h6E, 8'h00, 1);
    chk("R5 spare bits ignored chan", int'(chan_sel), 7);
    chk("R5 spare bits ignored single", int'(single_end), 0);

    // R10 bipolar reads, R11 reload after ack
    read_begin();
    read_one(-50, 1'b0, "R10 bipolar negative");
    read_one(200, 1'b0, "R10 bipolar clamp high");
    read_one(-256, 1'b1, "R10 bipolar clamp low");
    read_end();

    // R2 foreign address: nothing acked or written
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign address nack", int'(a), 0);
    send_byte(8'h81, a); chk("R2 data after foreign address nack", int'(a), 0);
    bus_stop(); settle();
    chk("R2 config kept", int'(chan_sel), 7);
    chk("R2 setup kept", int'(vref_sel), 3);

    // R7 setup update and config reset in the same write
    write_txn(8'hC8, 8'h00, 1);
    chk("R7 vref stored", int'(vref_sel), 4);
    chk("R7 extclk stored", int'(ext_clk_sel), 1);
    chk("R7 chan reset", int'(chan_sel), 0);
    chk("R7 single reset", int'(single_end), 1);

    // R7 reset bit 1 keeps the config
    write_txn(8'h0A, 8'h86, 2);
    chk("R7 chan kept", int'(chan_sel), 5);
    chk("R8 bipolar honoured", int'(bipolar_mode), 1);

    // R8 R9 single-ended forces unipolar
    write_txn(8'h0B, 8'h00, 1);
    chk("R8 single-ended forces unipolar", int'(bipolar_mode), 0);
    read_begin();
    read_one(-5, 1'b0, "R9 unipolar negative clamps");
    read_one(200, 1'b1, "R9 unipolar straight binary");
    read_end();

    // R9 differential unipolar
    write_txn(8'h82, 8'h0A, 2);
    read_begin();
    read_one(-100, 1'b0, "R9 differential unipolar negative");
    read_one(37, 1'b1, "R9 differential unipolar positive");
    read_end();

    // R12 STOP in mid-byte
    bus_start();
    send_byte({ADDR, 1'b0}, a); chk("R12 address ack", int'(a), 1);
    for (int i = 7; i >= 4; i--) send_bit(1'(8'h1E >> i));
    bus_stop(); settle();
    chk("R12 partial byte dropped on stop", int'(chan_sel), 5);

    // R12 repeated START in mid-byte
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    for (int i = 7; i >= 3; i--) send_bit(1'(8'h1E >> i));
    bus_start();
    send_byte({ADDR, 1'b0}, a); chk("R12 address ack after restart", int'(a), 1);
    send_byte(8'h03, a);        chk("R12 byte ack after restart", int'(a), 1);
    bus_stop();
    model_write(8'h03);
    settle();
    chk("R12 chan after restart", int'(chan_sel), 1);
    chk("R12 single after restart", int'(single_end), 1);

    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule